// File: doc/BRIEF.md
# Retriggerable Down Counter for Trigger Sequencing

This block is one counter of the kind a trigger sequencer uses to measure or wait on activity. It is a 40-bit down counter that takes its count pulses from one of three sources: qualified events, bus cycles or a fixed time tick. The mode input picks the source, so the same counter works as an event counter, a cycle counter or a timer. With a 100 ns tick, the full 40-bit range covers roughly 1.3 days. The tick is generated outside the block.

A restart strobe reloads the counter from the reload input at any time, so the counter is retriggerable. Counting only happens while the enable input is high. When the count reaches zero it stops there and raises a zero flag that the sequencer can use as a condition. The live count is always visible on a port. A host can also read the count in narrower words without stopping the counter: it first captures a snapshot of the whole count, then reads the words of that snapshot one at a time. Because every word comes from the same snapshot, a multi-word read never mixes two different counts.

All pins are plain control or status signals. There is no data stream, so no valid/ready handshake is needed. A word read returns the selected word combinationally, and it can never be held off.

Top module: `rtc_counter`

## Requirements
- R1: While reset is asserted and after it is released, `count` is 0, `zero` is 0, `zero_pulse` is 0 and `rd_word` is 0.
- R2: When `restart` is high at a clock edge, `count` takes `load_val` after that edge. This holds whatever `enable`, `mode` and the strobes are doing in the same cycle, so a reload always wins over a count pulse.
- R3: The `mode` encoding selects the count source:
  - 0 selects `ev_strb`.
  - 1 selects `cyc_strb`.
  - 2 selects `tick`.
  - 3 selects no source, so the counter never steps.
  - A strobe that the current mode does not select has no effect on `count`.
- R4: With `enable` high and the selected source high at an edge (and no restart), `count` decreases by exactly one. With `enable` low, `count` holds.
- R5: Once at 0, `count` stays at 0 under further count pulses. It never wraps to all ones.
- R6: `zero` is high exactly when at least one restart has occurred since reset and `count` is 0. This includes a restart that loads the value 0, in which case `zero` is high from the next cycle. `zero` stays high until a restart loads a non-zero value.
- R7: `zero_pulse` is high for exactly one cycle: the cycle after an edge at which a count pulse took `count` from 1 to 0. It is low at all other times.
- R8: A high `snap_req` at an edge captures `count` as it stood before that edge. The capture covers the bits that `rd_word` reads:
  - `rd_sel` = 0 gives bits 15:0.
  - `rd_sel` = 1 gives bits 31:16.
  - `rd_sel` = 2 gives bits 39:32, zero-extended to 16 bits.
  - `rd_sel` = 3 gives 0.

  The snapshot does not change until the next `snap_req`, even while the counter runs.
- R9: The `count` output always shows the current counter value, including while the counter is counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Count source: 0 event, 1 cycle, 2 time tick, 3 none |
| load_val | input | 40 | Value loaded by restart |
| restart | input | 1 | Reload strobe |
| enable | input | 1 | Count release |
| ev_strb | input | 1 | Qualified event pulse |
| cyc_strb | input | 1 | Bus cycle pulse |
| tick | input | 1 | Time base tick |
| snap_req | input | 1 | Capture live count into the read snapshot |
| rd_sel | input | 2 | Snapshot word select |
| zero | output | 1 | Counter is at zero after a reload |
| zero_pulse | output | 1 | One-cycle pulse on reaching zero by counting |
| count | output | 40 | Live counter value |
| rd_word | output | 16 | Selected snapshot word |

## Verification
These results appear one clock edge after the inputs that cause them:
- `count`, `zero`, `zero_pulse` and the snapshot all follow from that single edge.
- `rd_word` also depends on `rd_sel`, and it follows a change of `rd_sel` in the same cycle, with no clock edge needed.

The bench therefore changes inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. For the snapshot, it first counts further and only then reads the words, which shows that the words belong to the earlier capture and not to the live value.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [1:0] {
    SRC_EVENT = 2'd0,
    SRC_CYCLE = 2'd1,
    SRC_TIME  = 2'd2,
    SRC_NONE  = 2'd3
  } src_mode_t;
endpackage

// File: rtl/rtc_src_mux.sv
module rtc_src_mux
  import rtc_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       ev_strb,
  input  logic       cyc_strb,
  input  logic       tick,
  output logic       pulse
);
  src_mode_t m;
  assign m = src_mode_t'(mode);

  always_comb begin
    unique case (m)
      SRC_EVENT: pulse = ev_strb;
      SRC_CYCLE: pulse = cyc_strb;
      SRC_TIME:  pulse = tick;
      default:   pulse = 1'b0;
    endcase
  end
endmodule

// File: rtl/rtc_down_core.sv
module rtc_down_core #(
  parameter int CW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] load_val,
  input  logic          step,
  output logic [CW-1:0] count,
  output logic          zero,
  output logic          zero_pulse
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic          zp_q;
  logic          at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      zp_q    <= 1'b0;
    end else if (restart) begin
      cnt_q   <= load_val;
      armed_q <= 1'b1;
      zp_q    <= 1'b0;
    end else begin
      zp_q <= 1'b0;
      if (step && !at_zero) begin
        cnt_q <= cnt_q - ONE;
        if (cnt_q == ONE) zp_q <= 1'b1;
      end
    end
  end

  assign count      = cnt_q;
  assign zero       = armed_q & at_zero;
  assign zero_pulse = zp_q;
endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot #(
  parameter int CW = 40,
  parameter int WW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 capture,
  input  logic [CW-1:0]        live,
  input  logic [((((CW+WW-1)/WW) > 1) ? $clog2((CW+WW-1)/WW) : 1)-1:0] sel,
  output logic [WW-1:0]        word
);
  localparam int NW    = (CW + WW - 1) / WW;
  localparam int SELW  = (NW > 1) ? $clog2(NW) : 1;
  localparam int NSLOT = 1 << SELW;
  localparam int PADW  = NW * WW;

  logic [CW-1:0]   snap_q;
  logic [PADW-1:0] padded;
  logic [WW-1:0]   slots [NSLOT];

  always_ff @(posedge clk) begin
    if (!rst_n)       snap_q <= '0;
    else if (capture) snap_q <= live;
  end

  generate
    if (PADW > CW) begin : g_pad
      assign padded = {{(PADW-CW){1'b0}}, snap_q};
    end else begin : g_nopad
      assign padded = snap_q;
    end
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      if (g < NW) begin : g_used
        assign slots[g] = padded[g*WW +: WW];
      end else begin : g_empty
        assign slots[g] = '0;
      end
    end
  endgenerate

  assign word = slots[sel];
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int CW = 40,
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] load_val,
  input  logic          restart,
  input  logic          enable,
  input  logic          ev_strb,
  input  logic          cyc_strb,
  input  logic          tick,
  input  logic          snap_req,
  input  logic [((((CW+WW-1)/WW) > 1) ? $clog2((CW+WW-1)/WW) : 1)-1:0] rd_sel,
  output logic          zero,
  output logic          zero_pulse,
  output logic [CW-1:0] count,
  output logic [WW-1:0] rd_word
);
  logic pulse;
  logic step;

  rtc_src_mux u_mux (
    .mode     (mode),
    .ev_strb  (ev_strb),
    .cyc_strb (cyc_strb),
    .tick     (tick),
    .pulse    (pulse)
  );

  assign step = enable & pulse;

  rtc_down_core #(.CW(CW)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .load_val   (load_val),
    .step       (step),
    .count      (count),
    .zero       (zero),
    .zero_pulse (zero_pulse)
  );

  rtc_snapshot #(.CW(CW), .WW(WW)) u_snap (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (snap_req),
    .live    (count),
    .sel     (rd_sel),
    .word    (rd_word)
  );
endmodule

// File: rtl/rtc_counter_chk.sv
module rtc_counter_chk #(
  parameter int CW = 40,
  parameter int WW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic [CW-1:0] load_val,
  input logic          restart,
  input logic          enable,
  input logic          ev_strb,
  input logic          snap_req,
  input logic [((((CW+WW-1)/WW) > 1) ? $clog2((CW+WW-1)/WW) : 1)-1:0] rd_sel,
  input logic          zero,
  input logic          zero_pulse,
  input logic [CW-1:0] count,
  input logic [WW-1:0] rd_word
);
  assert_reload_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> count == $past(load_val));

  assert_hold_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !enable) |=> $stable(count));

  assert_event_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && enable && mode == 2'd0 && ev_strb && count != '0)
      |=> count == $past(count) - CW'(1));

  assert_idle_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && mode == 2'd3) |=> $stable(count));

  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && count == '0) |=> count == '0);

  assert_zero_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !restart) |=> zero);

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    zero |-> count == '0);

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_pulse |=> !zero_pulse);

  assert_pulse_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_pulse |-> (zero && count == '0));

  assert_snap_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req |=> (rd_sel != '0) || (rd_word == $past(count[WW-1:0])));

  assert_snap_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!snap_req && $stable(rd_sel)) |=> $stable(rd_word));
endmodule

bind rtc_counter rtc_counter_chk #(.CW(CW), .WW(WW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .load_val   (load_val),
  .restart    (restart),
  .enable     (enable),
  .ev_strb    (ev_strb),
  .snap_req   (snap_req),
  .rd_sel     (rd_sel),
  .zero       (zero),
  .zero_pulse (zero_pulse),
  .count      (count),
  .rd_word    (rd_word)
);

// File: tb/sim_rtc_counter.sv
module sim_rtc_counter;
  localparam int  CW      = 40;
  localparam int  WW      = 16;
  localparam time CLK_T   = 10ns;
  localparam int  WD_MAX  = 5000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    mode;
  logic [CW-1:0] load_val;
  logic          restart, enable, ev_strb, cyc_strb, tick, snap_req;
  logic [1:0]    rd_sel;
  logic          zero, zero_pulse;
  logic [CW-1:0] count;
  logic [WW-1:0] rd_word;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_n = 0;

  always #(CLK_T/2) clk = ~clk;

  rtc_counter #(.CW(CW), .WW(WW)) u0 (
    .clk, .rst_n, .mode, .load_val, .restart, .enable, .ev_strb,
    .cyc_strb, .tick, .snap_req, .rd_sel, .zero, .zero_pulse, .count, .rd_word
  );

  typedef struct packed {
    logic [1:0]  md;
    logic        rs, en, ev, cy, tk;
    logic [39:0] ld;
    logic [39:0] ec;
    logic        ez, ezp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 40'd5, 40'd5, 1'b0, 1'b0}, // R2 load
    '{2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 40'd0, 40'd4, 1'b0, 1'b0}, // R4 event step
    '{2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 40'd0, 40'd4, 1'b0, 1'b0}, // R4 disabled hold
    '{2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 40'd0, 40'd4, 1'b0, 1'b0}, // R3 wrong source
    '{2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 40'd0, 40'd3, 1'b0, 1'b0}, // R3 cycle mode
    '{2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 40'd0, 40'd2, 1'b0, 1'b0}, // R3 time mode
    '{2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 40'd0, 40'd2, 1'b0, 1'b0}, // R3 no source
    '{2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 40'd9, 40'd9, 1'b0, 1'b0}, // R2 reload wins
    '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 40'd2, 40'd2, 1'b0, 1'b0}, // R2 retrigger
    '{2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 40'd0, 40'd1, 1'b0, 1'b0}, // R4
    '{2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 40'd0, 40'd0, 1'b1, 1'b1}, // R6 R7 reach zero
    '{2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 40'd0, 40'd0, 1'b1, 1'b0}  // R5 R7 hold zero
  };

  task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    restart = 0; enable = 0; ev_strb = 0; cyc_strb = 0; tick = 0; snap_req = 0;
  endtask

  // one rising edge, then sample at the falling edge
  task automatic step_edge();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_n <= cyc_n + 1;
    if (cyc_n > WD_MAX) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc_n, WD_MAX);
      finish_run();
    end
  end

  initial begin
    rst_n = 0; mode = 0; load_val = '0; rd_sel = 0;
    idle();
    @(negedge clk); @(negedge clk);
    check("R1 count in reset", count, '0);
    check("R1 zero in reset", CW'(zero), '0);
    rst_n = 1;
    step_edge();
    check("R1 count after reset", count, '0);
    check("R1 zero after reset", CW'(zero), '0);
    check("R1 zero_pulse after reset", CW'(zero_pulse), '0);
    check("R1 rd_word after reset", CW'(rd_word), '0);

    for (int i = 0; i < NV; i++) begin
      mode = VEC[i].md; restart = VEC[i].rs; enable = VEC[i].en;
      ev_strb = VEC[i].ev; cyc_strb = VEC[i].cy; tick = VEC[i].tk;
      load_val = VEC[i].ld;
      step_edge();
      check($sformatf("R2/R3/R4/R5 vec%0d count", i), count, VEC[i].ec);
      check($sformatf("R6 vec%0d zero", i), CW'(zero), CW'(VEC[i].ez));
      check($sformatf("R7 vec%0d zero_pulse", i), CW'(zero_pulse), CW'(VEC[i].ezp));
    end
    idle();

    // R6: reload with zero sets zero flag at once, non-zero reload clears it
    restart = 1; load_val = '0;
    step_edge();
    check("R6 zero after zero reload", CW'(zero), 1);
    check("R7 no pulse on zero reload", CW'(zero_pulse), 0);
    load_val = 40'd3;
    step_edge();
    check("R6 zero cleared by reload", CW'(zero), 0);

    // R4 at full range
    load_val = {CW{1'b1}};
    step_edge();
    restart = 0; enable = 1; mode = 2'd1; cyc_strb = 1;
    step_edge();
    check("R4 step from all ones", count, {{(CW-1){1'b1}}, 1'b0});
    idle();

    // R8 snapshot, R9 live count
    restart = 1; load_val = 40'hAB_CDEF_1234;
    step_edge();
    restart = 0; snap_req = 1;
    step_edge();
    snap_req = 0; mode = 2'd0; enable = 1; ev_strb = 1;
    step_edge(); step_edge(); step_edge();
    idle();
    check("R9 live count running", count, 40'hAB_CDEF_1231);
    rd_sel = 0; #1;
    check("R8 word0 frozen", CW'(rd_word), 40'h1234);
    rd_sel = 1; #1;
    check("R8 word1", CW'(rd_word), 40'hCDEF);
    rd_sel = 2; #1;
    check("R8 word2 zero-extended", CW'(rd_word), 40'h00AB);
    rd_sel = 3; #1;
    check("R8 word3 empty", CW'(rd_word), '0);
    rd_sel = 0;
    snap_req = 1;
    step_edge();
    snap_req = 0; #1;
    check("R8 recapture", CW'(rd_word), 40'h1231);

    finish_run();
  end
endmodule